// File: doc/BRIEF.md
# Reset vector fetch sequencer

This block brings a processor core out of reset by reading its boot state from a vector table in memory. Once reset is released, or when a warm boot is requested after an earlier sequence has finished, it issues two word reads on a simple request/valid memory port. The word at the table base becomes the initial stack pointer. The word at base + 4 becomes the start address. Bit 0 of the start address is a flag that selects the instruction-set state. The program counter takes the start address with bit 0 cleared. The link register is preset to all ones during every sequence.

A completed sequence ends with a one-cycle start pulse, and the stack pointer, program counter, link register and state flag are valid in that same cycle. If the fetched state flag is 0, the block raises a fault output and gives no start pulse. The table base lives in a register that software can write and read back. Address bits below the alignment boundary always read as zero. That boundary follows from the number of exception entries, a parameter. A sequence that is already running uses the base latched when it began, so a new base takes effect only on the following sequence.

Top module: `boot_vec_seq`

## Requirements
- R1: Each sequence first requests the word at table base + 0, and the returned word appears on `sp_o` in the cycle after `mem_rvalid_i` is accepted.
- R2: The second request, for base + 4, is presented in the cycle after the first response. After it completes, `pc_o` holds the returned word with bit 0 cleared and `isa_flag_o` holds that word's bit 0.
- R3: `lr_o` reads 0xFFFFFFFF whenever a sequence has completed.
- R4: When bit 0 of the second word is 1, `start_o` is high for exactly one cycle, the cycle after the second response, and `fault_o` stays low.
- R5: When bit 0 of the second word is 0, `fault_o` rises in the cycle after the second response instead of `start_o`. It stays high until the next sequence launches.
- R6: `mem_req_o` stays high and `mem_addr_o` stays stable until `mem_rvalid_i` is seen. A `mem_rvalid_i` with no request outstanding changes no output.
- R7: While `rst_n` is low, the table base reads 0 and `start_o`, `fault_o` and `mem_req_o` are low. After release, a sequence runs from base 0.
- R8: The alignment size is 4 × max(32, NUM_ENTRIES rounded up to a power of two) bytes. Base bits below that boundary read back as zero whatever is written (with the default 48 entries, bits 7:0). A write shows on `cfg_rd_data_o` one cycle later.
- R9: A base write made while a sequence is fetching does not change that sequence's addresses. The next sequence uses the new base.
- R10: A pulse on `warm_boot_i` after completion or fault starts a new sequence. The same pulse during a fetch is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| warm_boot_i | input | 1 | Request a new sequence using the current base |
| cfg_wr_en_i | input | 1 | Write strobe for the table base register |
| cfg_wr_data_i | input | WORD_W | Table base write value |
| cfg_rd_data_o | output | WORD_W | Table base readback (aligned) |
| mem_req_o | output | 1 | Read request, held until a response |
| mem_addr_o | output | WORD_W | Byte address of the requested word |
| mem_rvalid_i | input | 1 | Read response valid |
| mem_rdata_i | input | WORD_W | Read response data |
| start_o | output | 1 | One-cycle start pulse |
| sp_o | output | WORD_W | Initial stack pointer |
| pc_o | output | WORD_W | Start address, bit 0 cleared |
| lr_o | output | WORD_W | Link register preset |
| isa_flag_o | output | 1 | Instruction-set state flag from bit 0 of the start word |
| fault_o | output | 1 | Start word had a clear state flag |

## Verification
Every result lands one clock after its cause. `sp_o` and the second request's address follow the first response by one cycle. `pc_o`, `isa_flag_o`, `lr_o` and either `start_o` or `fault_o` follow the second response by one cycle, and `start_o` falls again one cycle after that. Base readback follows a write by one cycle.

The start of a request is not fixed to one cycle, because it depends on the reset synchronizer and on the launch cycle. The bench therefore polls for `mem_req_o` with a bounded wait. It then drives each response on a falling edge and samples every expected value on the next falling edge, exactly one rising edge later. Random response latencies, random vectors and random base writes are mixed with directed alignment, fault, stray-response and mid-fetch write cases.

// File: rtl/bvs_pkg.sv
package bvs_pkg;

  typedef enum logic [2:0] {
    ST_LAUNCH   = 3'd0,
    ST_FETCH_SP = 3'd1,
    ST_FETCH_PC = 3'd2,
    ST_RUN      = 3'd3,
    ST_FAULT    = 3'd4
  } seq_state_e;

  // Words occupied by the table, rounded up to a power of two, never below 32.
  function automatic int unsigned table_words(input int unsigned entries);
    int unsigned w;
    w = 1;
    for (int i = 0; i < 31; i++) begin
      if (w < entries) w = w << 1;
    end
    if (w < 32) w = 32;
    return w;
  endfunction

  // log2 of the base alignment in bytes.
  function automatic int unsigned align_log2(input int unsigned entries);
    return $clog2(table_words(entries)) + 2;
  endfunction

endpackage

// File: rtl/bvs_rst_sync.sv
module bvs_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/bvs_base_reg.sv
module bvs_base_reg #(
  parameter int WORD_W     = 32,
  parameter int ALIGN_LOG2 = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en_i,
  input  logic [WORD_W-1:0] wr_data_i,
  output logic [WORD_W-1:0] base_o
);

  localparam int HI_W = WORD_W - ALIGN_LOG2;

  // Only the bits above the alignment boundary are stored.
  logic [HI_W-1:0] hi_q;
  logic [HI_W-1:0] hi_d;
  logic            unused_low_bits;

  always_comb begin
    hi_d = hi_q;
    if (wr_en_i) hi_d = wr_data_i[WORD_W-1:ALIGN_LOG2];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q <= '0;
    end else if (wr_en_i) begin
      hi_q <= hi_d;
    end
  end

  assign unused_low_bits = ^wr_data_i[ALIGN_LOG2-1:0];
  assign base_o          = {hi_q, {ALIGN_LOG2{1'b0}}};

endmodule

// File: rtl/bvs_fsm.sv
module bvs_fsm
  import bvs_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic warm_boot_i,
  input  logic rvalid_i,
  input  logic vec_bit0_i,
  output logic launch_o,
  output logic sp_load_o,
  output logic pc_load_o,
  output logic start_set_o,
  output logic fault_set_o,
  output logic req_o,
  output logic hi_word_o
);

  seq_state_e state_q;
  seq_state_e state_d;

  always_comb begin
    state_d     = state_q;
    launch_o    = 1'b0;
    sp_load_o   = 1'b0;
    pc_load_o   = 1'b0;
    start_set_o = 1'b0;
    fault_set_o = 1'b0;
    unique case (state_q)
      ST_LAUNCH: begin
        launch_o = 1'b1;
        state_d  = ST_FETCH_SP;
      end
      ST_FETCH_SP: begin
        if (rvalid_i) begin
          sp_load_o = 1'b1;
          state_d   = ST_FETCH_PC;
        end
      end
      ST_FETCH_PC: begin
        if (rvalid_i) begin
          pc_load_o = 1'b1;
          if (vec_bit0_i) begin
            start_set_o = 1'b1;
            state_d     = ST_RUN;
          end else begin
            fault_set_o = 1'b1;
            state_d     = ST_FAULT;
          end
        end
      end
      ST_RUN, ST_FAULT: begin
        if (warm_boot_i) state_d = ST_LAUNCH;
      end
      default: state_d = ST_LAUNCH;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_LAUNCH;
    end else begin
      state_q <= state_d;
    end
  end

  assign req_o     = (state_q == ST_FETCH_SP) || (state_q == ST_FETCH_PC);
  assign hi_word_o = (state_q == ST_FETCH_PC);

endmodule

// File: rtl/bvs_capture.sv
module bvs_capture #(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              launch_i,
  input  logic              sp_load_i,
  input  logic              pc_load_i,
  input  logic              start_set_i,
  input  logic              fault_set_i,
  input  logic [WORD_W-1:0] base_i,
  input  logic [WORD_W-1:0] rdata_i,
  output logic [WORD_W-1:0] seq_base_o,
  output logic [WORD_W-1:0] sp_o,
  output logic [WORD_W-1:0] pc_o,
  output logic [WORD_W-1:0] lr_o,
  output logic              isa_flag_o,
  output logic              start_o,
  output logic              fault_o
);

  localparam logic [WORD_W-1:0] LR_PRESET = '1;

  logic [WORD_W-1:0] seq_base_q, sp_q, pc_q, lr_q;
  logic              flag_q, start_q, fault_q;
  logic              fault_d;

  // Base latched per sequence: later writes cannot move an ongoing fetch.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seq_base_q <= '0;
      lr_q       <= '0;
    end else if (launch_i) begin
      seq_base_q <= base_i;
      lr_q       <= LR_PRESET;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sp_q <= '0;
    end else if (sp_load_i) begin
      sp_q <= rdata_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q   <= '0;
      flag_q <= 1'b0;
    end else if (pc_load_i) begin
      pc_q   <= {rdata_i[WORD_W-1:1], 1'b0};
      flag_q <= rdata_i[0];
    end
  end

  always_comb begin
    fault_d = fault_q;
    if (launch_i)    fault_d = 1'b0;
    if (fault_set_i) fault_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q <= 1'b0;
      fault_q <= 1'b0;
    end else begin
      start_q <= start_set_i;
      fault_q <= fault_d;
    end
  end

  assign seq_base_o = seq_base_q;
  assign sp_o       = sp_q;
  assign pc_o       = pc_q;
  assign lr_o       = lr_q;
  assign isa_flag_o = flag_q;
  assign start_o    = start_q;
  assign fault_o    = fault_q;

endmodule

// File: rtl/boot_vec_seq.sv
module boot_vec_seq
  import bvs_pkg::*;
#(
  parameter int WORD_W      = 32,
  parameter int NUM_ENTRIES = 48,
  parameter int RST_STAGES  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              warm_boot_i,
  input  logic              cfg_wr_en_i,
  input  logic [WORD_W-1:0] cfg_wr_data_i,
  output logic [WORD_W-1:0] cfg_rd_data_o,
  output logic              mem_req_o,
  output logic [WORD_W-1:0] mem_addr_o,
  input  logic              mem_rvalid_i,
  input  logic [WORD_W-1:0] mem_rdata_i,
  output logic              start_o,
  output logic [WORD_W-1:0] sp_o,
  output logic [WORD_W-1:0] pc_o,
  output logic [WORD_W-1:0] lr_o,
  output logic              isa_flag_o,
  output logic              fault_o
);

  localparam int                ALIGN_LOG2 = align_log2(NUM_ENTRIES);
  localparam logic [WORD_W-1:0] SECOND_OFS = WORD_W'(4);

  logic              rst_sync_n;
  logic              launch, sp_load, pc_load, start_set, fault_set;
  logic              hi_word;
  logic [WORD_W-1:0] base_cur;
  logic [WORD_W-1:0] seq_base;

  bvs_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  bvs_base_reg #(.WORD_W(WORD_W), .ALIGN_LOG2(ALIGN_LOG2)) u_base (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .wr_en_i   (cfg_wr_en_i),
    .wr_data_i (cfg_wr_data_i),
    .base_o    (base_cur)
  );

  bvs_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .warm_boot_i (warm_boot_i),
    .rvalid_i    (mem_rvalid_i),
    .vec_bit0_i  (mem_rdata_i[0]),
    .launch_o    (launch),
    .sp_load_o   (sp_load),
    .pc_load_o   (pc_load),
    .start_set_o (start_set),
    .fault_set_o (fault_set),
    .req_o       (mem_req_o),
    .hi_word_o   (hi_word)
  );

  bvs_capture #(.WORD_W(WORD_W)) u_cap (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .launch_i    (launch),
    .sp_load_i   (sp_load),
    .pc_load_i   (pc_load),
    .start_set_i (start_set),
    .fault_set_i (fault_set),
    .base_i      (base_cur),
    .rdata_i     (mem_rdata_i),
    .seq_base_o  (seq_base),
    .sp_o        (sp_o),
    .pc_o        (pc_o),
    .lr_o        (lr_o),
    .isa_flag_o  (isa_flag_o),
    .start_o     (start_o),
    .fault_o     (fault_o)
  );

  assign mem_addr_o    = hi_word ? (seq_base + SECOND_OFS) : seq_base;
  assign cfg_rd_data_o = base_cur;

endmodule

// File: rtl/bvs_chk.sv
module bvs_chk
  import bvs_pkg::*;
#(
  parameter int WORD_W      = 32,
  parameter int NUM_ENTRIES = 48
) (
  input logic              clk,
  input logic              rst_n,
  input logic              warm_boot_i,
  input logic [WORD_W-1:0] cfg_rd_data_o,
  input logic              mem_req_o,
  input logic [WORD_W-1:0] mem_addr_o,
  input logic              mem_rvalid_i,
  input logic              start_o,
  input logic [WORD_W-1:0] pc_o,
  input logic [WORD_W-1:0] lr_o,
  input logic              isa_flag_o,
  input logic              fault_o
);

  localparam int                ALIGN_LOG2 = align_log2(NUM_ENTRIES);
  localparam logic [WORD_W-1:0] LOW_MASK   =
    {{(WORD_W-ALIGN_LOG2){1'b0}}, {ALIGN_LOG2{1'b1}}};

  AST_PC_EVEN_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
    start_o |-> (isa_flag_o && pc_o == {pc_o[WORD_W-1:1], 1'b0})); // R2
  AST_LR_ALL_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    start_o |-> (lr_o == '1)); // R3
  AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    start_o |=> !start_o); // R4
  AST_FAULT_EXCLUDES_START: assert property (@(posedge clk) disable iff (!rst_n)
    fault_o |-> !start_o); // R5
  AST_FAULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_o && !warm_boot_i && !$past(warm_boot_i)) |=> fault_o); // R5
  AST_REQ_HELD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_o && !mem_rvalid_i) |=> (mem_req_o && $stable(mem_addr_o))); // R6
  AST_BASE_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rd_data_o & LOW_MASK) == '0); // R8

endmodule

bind boot_vec_seq bvs_chk #(.WORD_W(WORD_W), .NUM_ENTRIES(NUM_ENTRIES)) chk_i (
  .clk           (clk),
  .rst_n         (rst_n),
  .warm_boot_i   (warm_boot_i),
  .cfg_rd_data_o (cfg_rd_data_o),
  .mem_req_o     (mem_req_o),
  .mem_addr_o    (mem_addr_o),
  .mem_rvalid_i  (mem_rvalid_i),
  .start_o       (start_o),
  .pc_o          (pc_o),
  .lr_o          (lr_o),
  .isa_flag_o    (isa_flag_o),
  .fault_o       (fault_o)
);

// File: tb/boot_vec_seq_tb.sv
module boot_vec_seq_tb_top;

  localparam int W       = 32;
  localparam int ENTRIES = 48;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         warm_boot_i;
  logic         cfg_wr_en_i;
  logic [W-1:0] cfg_wr_data_i;
  logic [W-1:0] cfg_rd_data_o;
  logic         mem_req_o;
  logic [W-1:0] mem_addr_o;
  logic         mem_rvalid_i;
  logic [W-1:0] mem_rdata_i;
  logic         start_o;
  logic [W-1:0] sp_o, pc_o, lr_o;
  logic         isa_flag_o;
  logic         fault_o;

  int           total = 0;
  int           bad   = 0;
  logic [W-1:0] cur_base;

  always #4 clk = ~clk;

  boot_vec_seq #(.WORD_W(W), .NUM_ENTRIES(ENTRIES)) dut_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .warm_boot_i   (warm_boot_i),
    .cfg_wr_en_i   (cfg_wr_en_i),
    .cfg_wr_data_i (cfg_wr_data_i),
    .cfg_rd_data_o (cfg_rd_data_o),
    .mem_req_o     (mem_req_o),
    .mem_addr_o    (mem_addr_o),
    .mem_rvalid_i  (mem_rvalid_i),
    .mem_rdata_i   (mem_rdata_i),
    .start_o       (start_o),
    .sp_o          (sp_o),
    .pc_o          (pc_o),
    .lr_o          (lr_o),
    .isa_flag_o    (isa_flag_o),
    .fault_o       (fault_o)
  );

  // Alignment from the requirement: 4 * max(32, pow2ceil(entries)) bytes.
  function automatic logic [W-1:0] keep_mask();
    int unsigned words = 1;
    while (words < ENTRIES) words = words * 2;
    if (words < 32) words = 32;
    return ~(W'(words * 4) - W'(1));
  endfunction

  task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic wait_req(output bit ok);
    ok = 1'b0;
    for (int i = 0; i < 20; i++) begin
      if (mem_req_o) begin
        ok = 1'b1;
        break;
      end
      tick();
    end
    if (!ok) chk("R10 request never issued", 0, 1);
  endtask

  task automatic cfg_write(input logic [W-1:0] val);
    cfg_wr_en_i   = 1'b1;
    cfg_wr_data_i = val;
    tick();
    cfg_wr_en_i = 1'b0;
    chk("R8 base readback masked", cfg_rd_data_o, val & keep_mask());
    cur_base = val & keep_mask();
  endtask

  task automatic warm_pulse();
    warm_boot_i = 1'b1;
    tick();
    warm_boot_i = 1'b0;
  endtask

  task automatic run_boot(input logic [W-1:0] base, input logic [W-1:0] spv,
                          input logic [W-1:0] pcv, input int l1, input int l2,
                          input bit inject, input logic [W-1:0] wv);
    bit ok;
    wait_req(ok);
    if (!ok) return;
    chk("R1 first address", mem_addr_o, base);
    chk("R5 fault cleared at launch", W'(fault_o), 0);
    for (int i = 0; i < l1; i++) begin
      if (inject && i == 0) begin
        cfg_wr_en_i   = 1'b1;
        cfg_wr_data_i = wv;
        warm_boot_i   = 1'b1;
      end
      tick();
      cfg_wr_en_i = 1'b0;
      warm_boot_i = 1'b0;
      chk("R6 request held", W'(mem_req_o), 1);
      chk("R9 address unchanged by write", mem_addr_o, base);
      if (inject && i == 0) begin
        chk("R8 write during fetch readback", cfg_rd_data_o, wv & keep_mask());
        cur_base = wv & keep_mask();
      end
    end
    mem_rvalid_i = 1'b1;
    mem_rdata_i  = spv;
    tick();
    mem_rvalid_i = 1'b0;
    mem_rdata_i  = '0;
    chk("R1 stack pointer", sp_o, spv);
    chk("R2 second request", W'(mem_req_o), 1);
    chk("R2 second address", mem_addr_o, base + 4);
    for (int i = 0; i < l2; i++) begin
      tick();
      chk("R6 second address stable", mem_addr_o, base + 4);
    end
    mem_rvalid_i = 1'b1;
    mem_rdata_i  = pcv;
    tick();
    mem_rvalid_i = 1'b0;
    mem_rdata_i  = '0;
    chk("R2 program counter", pc_o, pcv & ~W'(1));
    chk("R2 state flag", W'(isa_flag_o), W'(pcv[0]));
    chk("R3 link register", lr_o, '1);
    chk("R1 stack pointer kept", sp_o, spv);
    chk("R4 start pulse", W'(start_o), W'(pcv[0]));
    chk("R5 fault raised", W'(fault_o), W'(!pcv[0]));
    tick();
    chk("R4 start falls", W'(start_o), 0);
    chk("R10 no relaunch from ignored pulse", W'(mem_req_o), 0);
    if (!pcv[0]) chk("R5 fault held", W'(fault_o), 1);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    logic [W-1:0] stray;
    bit ok;
    void'($urandom(32'd20240611));
    rst_n = 1'b0;
    warm_boot_i = 1'b0;
    cfg_wr_en_i = 1'b0;
    cfg_wr_data_i = '0;
    mem_rvalid_i = 1'b0;
    mem_rdata_i = '0;
    cur_base = '0;
    repeat (3) tick();
    chk("R7 reset base", cfg_rd_data_o, 0);
    chk("R7 reset start", W'(start_o), 0);
    chk("R7 reset fault", W'(fault_o), 0);
    chk("R7 reset request", W'(mem_req_o), 0);
    rst_n = 1'b1;
    run_boot(32'h0, 32'h2000_1000, 32'h0000_0101, 0, 0, 1'b0, '0);

    // Alignment corner cases.
    cfg_write(32'hFFFF_FFFF);
    cfg_write(32'h2000_0080);
    chk("R8 low bits dropped", cfg_rd_data_o, 32'h2000_0000);

    // Stray response while idle.
    mem_rvalid_i = 1'b1;
    mem_rdata_i  = 32'hDEAD_BEEF;
    tick();
    mem_rvalid_i = 1'b0;
    tick();
    chk("R6 stray response sp", sp_o, 32'h2000_1000);
    chk("R6 stray response pc", pc_o, 32'h0000_0100);
    chk("R6 stray no start", W'(start_o), 0);

    // Fault case with latency, then stray response in fault state.
    warm_pulse();
    run_boot(cur_base, 32'h2000_2000, 32'h0000_4444, 2, 1, 1'b0, '0);
    repeat (3) tick();
    chk("R5 fault persists", W'(fault_o), 1);

    // Write during fetch: current sequence unaffected, next one relocated.
    warm_pulse();
    run_boot(cur_base, 32'h1111_0000, 32'h0000_0201, 2, 0, 1'b1, 32'h3000_05FF);
    warm_pulse();
    run_boot(32'h3000_0500, 32'h2222_0000, 32'h0000_0301, 0, 2, 1'b0, '0);

    // Random sequences.
    for (int it = 0; it < 40; it++) begin
      logic [W-1:0] spv, pcv;
      int l1, l2;
      bit inj;
      spv = $urandom;
      pcv = $urandom;
      pcv[0] = ($urandom % 5) != 0;
      if ($urandom % 2) cfg_write($urandom);
      warm_pulse();
      l1  = $urandom % 4;
      l2  = $urandom % 4;
      inj = (l1 > 0) && (($urandom % 3) == 0);
      run_boot(cur_base, spv, pcv, l1, l2, inj, $urandom);
    end

    // Reset in the middle brings the base back to zero.
    cfg_write(32'h4000_0000);
    rst_n = 1'b0;
    tick();
    chk("R7 base cleared by reset", cfg_rd_data_o, 0);
    rst_n = 1'b1;
    cur_base = '0;
    wait_req(ok);
    chk("R7 sequence from base zero", mem_addr_o, 0);
    stray = $urandom;
    mem_rvalid_i = 1'b1;
    mem_rdata_i  = stray;
    tick();
    mem_rvalid_i = 1'b0;
    chk("R1 stack pointer after reset", sp_o, stray);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule